// File: doc/BRIEF.md
# Protected Clock Control Register File

This block keeps two 8-bit clock control registers and turns their contents into a CPU clock enable. Software writes the registers over a small bus port with an address, write data and a write strobe. A write lands only while an external protect-enable bit is high. The read port returns the addressed register at once, and reserved positions always read their fixed values.

The CPU clock enable is a one-cycle pulse once every N base clocks. N is chosen in one of two ways. When the override bit in the first register is set, N is 8. When that bit is clear, a two-bit field in the second register picks N from 1, 2, 4 and 16. A new ratio takes effect only when the period in progress ends, so no pulse ever comes early.

Writing the stop bit of the second register puts the block in stop mode, and the enable stays low. If this happens while the main oscillator is selected, hardware also sets the divide-by-8 override and the high-drive bit. A wake input clears the stop bit. The low-speed oscillator stop bit is held at zero while the on-chip oscillator is selected. The peripheral wait gate and both oscillator stop controls are driven straight from register bits.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset, register 0 (address 0) reads 0x68 and register 1 (address 1) reads 0x20.
- R2: A write strobe while `prot_en` is 0 leaves both registers unchanged.
- R3: While register 0 bit 6 is 1, `cpu_clk_en` pulses once every 8 clocks, whatever register 1 bits 7:6 hold.
- R4: While register 0 bit 6 is 0, register 1 bits 7:6 set the pulse period: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16 clocks. Each pulse is high for one cycle, except at period 1, where the enable stays high.
- R5: A write that sets register 1 bit 0 while it is 0 and `osc_sel` is 0 also sets register 0 bit 6 and register 1 bit 5. With `osc_sel` at 1, neither bit changes.
- R6: While `osc_sel` is 1, register 1 bit 4 is cleared within one clock and writes of 1 to it are ignored. While `osc_sel` is 0, the bit can be written.
- R7: `periph_wait_gate` equals register 0 bit 2, `main_osc_stop` equals register 0 bit 5, and `lso_stop` equals register 1 bit 4.
- R8: Register 0 bits 7, 4, 1 and 0 read 0 and bit 3 reads 1. Register 1 bits 2:1 read 0. Writing 0xFF to register 0 reads back 0x6C, and writing 0xFE to register 1 reads back 0xF8.
- R9: While register 1 bit 0 (stop) is 1, `cpu_clk_en` stays 0.
- R10: When `wake` is 1 in stop mode, register 1 bit 0 reads 0 on the next cycle.
- R11: A ratio change written partway through a period lets that period finish at its old length. The following period uses the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 or 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| prot_en | input | 1 | Write enable from the protection register |
| osc_sel | input | 1 | 1 when the on-chip oscillator is selected as the clock source |
| wake | input | 1 | Wake request that ends stop mode |
| cpu_clk_en | output | 1 | Divided CPU clock enable pulse |
| periph_wait_gate | output | 1 | Stop the peripheral clock in wait mode |
| main_osc_stop | output | 1 | Stop the main oscillator |
| lso_stop | output | 1 | Stop the low-speed oscillator |

## Verification
The assertions assume that `prot_en`, `osc_sel` and `wake` are synchronous to `clk` and that each holds for a whole cycle. They also assume the bus performs at most one write per cycle. The stop-entry check further assumes no wake arrives in the cycle that sets the stop bit. The bench changes every input on the falling edge, keeps each write strobe to one cycle, and raises `wake` only after stop mode has settled, so all of these assumptions hold.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned REG_W = 8;
    localparam int unsigned CNT_W = 5;

    localparam logic [REG_W-1:0] R0_RESET = 8'h68;
    localparam logic [REG_W-1:0] R1_RESET = 8'h20;
    localparam logic [REG_W-1:0] R0_WMASK = 8'b0110_0100;
    localparam logic [REG_W-1:0] R0_ONES  = 8'b0000_1000;
    localparam logic [REG_W-1:0] R1_WMASK = 8'b1111_1001;

    localparam int unsigned B0_PGATE = 2;
    localparam int unsigned B0_MSTOP = 5;
    localparam int unsigned B0_DIV8  = 6;
    localparam int unsigned B1_STOP  = 0;
    localparam int unsigned B1_LSO   = 4;
    localparam int unsigned B1_DRIVE = 5;

    typedef enum logic [2:0] {
        DIV_1, DIV_2, DIV_4, DIV_8, DIV_16
    } div_e;

    function automatic div_e pick_div(logic [REG_W-1:0] r0, logic [REG_W-1:0] r1);
        if (r0[B0_DIV8]) return DIV_8;
        unique case (r1[7:6])
            2'b00:   return DIV_1;
            2'b01:   return DIV_2;
            2'b10:   return DIV_4;
            default: return DIV_16;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] div_last(div_e d);
        unique case (d)
            DIV_1:   return CNT_W'(0);
            DIV_2:   return CNT_W'(1);
            DIV_4:   return CNT_W'(3);
            DIV_8:   return CNT_W'(7);
            default: return CNT_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             prot_en,
    input  logic             osc_sel,
    input  logic             wake,
    output logic [REG_W-1:0] r0_q,
    output logic [REG_W-1:0] r1_q
);

    logic             wr_ok;
    logic             stop_entry;
    logic [REG_W-1:0] r0_d;
    logic [REG_W-1:0] r1_d;

    assign wr_ok      = bus_wr && prot_en;
    assign stop_entry = wr_ok && bus_addr && bus_wdata[B1_STOP] && !r1_q[B1_STOP] && !osc_sel;

    always_comb begin
        r0_d = r0_q;
        r1_d = r1_q;
        if (wr_ok && !bus_addr) r0_d = (bus_wdata & R0_WMASK) | R0_ONES;
        if (wr_ok && bus_addr)  r1_d = bus_wdata & R1_WMASK;
        if (stop_entry) begin
            r0_d[B0_DIV8]  = 1'b1;
            r1_d[B1_DRIVE] = 1'b1;
        end
        if (osc_sel) r1_d[B1_LSO] = 1'b0;
        if (r1_q[B1_STOP] && wake) r1_d[B1_STOP] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r0_q <= R0_RESET;
            r1_q <= R1_RESET;
        end else begin
            r0_q <= r0_d;
            r1_q <= r1_d;
        end
    end

    assert_prot_r0_R2: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> $stable(r0_q));
    assert_prot_r1_R2: assert property (@(posedge clk) disable iff (rst)
        (!prot_en && !osc_sel && !wake) |=> $stable(r1_q));
    assert_stop_side_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && prot_en && bus_addr && bus_wdata[B1_STOP] && !r1_q[B1_STOP] && !osc_sel && !wake)
        |=> (r0_q[B0_DIV8] && r1_q[B1_DRIVE] && r1_q[B1_STOP]));
    assert_lso_forced_R6: assert property (@(posedge clk) disable iff (rst)
        osc_sel |=> !r1_q[B1_LSO]);
    assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
        ((r0_q & 8'b1001_0011) == 8'h00) && r0_q[3] && (r1_q[2:1] == 2'b00));
    assert_wake_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (r1_q[B1_STOP] && wake) |=> !r1_q[B1_STOP]);

endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop,
    input  div_e sel,
    output logic cpu_clk_en
);

    div_e             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end     = (cnt_q == div_last(act_q));
    assign cpu_clk_en = !stop && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= DIV_8;
            cnt_q <= '0;
        end else if (stop || at_end) begin
            act_q <= sel;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        stop |-> !cpu_clk_en);
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && sel != DIV_1) |=> !cpu_clk_en);
    assert_ratio_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!stop && !at_end) |=> $stable(act_q));

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             prot_en,
    input  logic             osc_sel,
    input  logic             wake,
    output logic             cpu_clk_en,
    output logic             periph_wait_gate,
    output logic             main_osc_stop,
    output logic             lso_stop
);

    logic [REG_W-1:0] r0;
    logic [REG_W-1:0] r1;
    div_e             div_sel;

    clkctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .prot_en   (prot_en),
        .osc_sel   (osc_sel),
        .wake      (wake),
        .r0_q      (r0),
        .r1_q      (r1)
    );

    assign div_sel = pick_div(r0, r1);

    clkctl_divider u_div (
        .clk        (clk),
        .rst        (rst),
        .stop       (r1[B1_STOP]),
        .sel        (div_sel),
        .cpu_clk_en (cpu_clk_en)
    );

    assign bus_rdata        = bus_addr ? r1 : r0;
    assign periph_wait_gate = r0[B0_PGATE];
    assign main_osc_stop    = r0[B0_MSTOP];
    assign lso_stop         = r1[B1_LSO];

endmodule

// File: tb/clkctl_regfile_tb_top.sv
module clkctl_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       prot_en = 1'b1;
    logic       osc_sel = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_clk_en;
    logic       periph_wait_gate;
    logic       main_osc_stop;
    logic       lso_stop;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clkctl_regfile dut_i (
        .clk              (clk),
        .rst              (rst),
        .bus_wr           (bus_wr),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .prot_en          (prot_en),
        .osc_sel          (osc_sel),
        .wake             (wake),
        .cpu_clk_en       (cpu_clk_en),
        .periph_wait_gate (periph_wait_gate),
        .main_osc_stop    (main_osc_stop),
        .lso_stop         (lso_stop)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic measure_period(output int p);
        p = 0;
        for (int i = 0; i < 64 && !cpu_clk_en; i++) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            p++;
            if (cpu_clk_en) break;
        end
    endtask

    task automatic settled_period(output int p);
        int dummy;
        measure_period(dummy);
        measure_period(p);
    endtask

    task automatic t_reset;
        int p;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_chk("R1 reg0 reset", 1'b0, 8'h68);
        read_chk("R1 reg1 reset", 1'b1, 8'h20);
        check("R7 periph gate reset", int'(periph_wait_gate), 0);
        check("R7 main stop reset", int'(main_osc_stop), 1);
        check("R7 lso stop reset", int'(lso_stop), 0);
        settled_period(p);
        check("R3 reset period", p, 8);
    endtask

    task automatic t_protect;
        prot_en = 1'b0;
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'hC0);
        read_chk("R2 reg0 protected", 1'b0, 8'h68);
        read_chk("R2 reg1 protected", 1'b1, 8'h20);
        prot_en = 1'b1;
    endtask

    task automatic t_reserved;
        int p;
        bus_write(1'b0, 8'hFF);
        read_chk("R8 reg0 all ones", 1'b0, 8'h6C);
        check("R7 periph gate set", int'(periph_wait_gate), 1);
        check("R7 main stop set", int'(main_osc_stop), 1);
        bus_write(1'b1, 8'hFE);
        read_chk("R8 reg1 all ones", 1'b1, 8'hF8);
        check("R7 lso stop set", int'(lso_stop), 1);
        settled_period(p);
        check("R3 override beats ratio field", p, 8);
    endtask

    task automatic t_ratios;
        int p;
        int exp_p[4] = '{1, 2, 4, 16};
        bus_write(1'b0, 8'h00);
        check("R7 periph gate clear", int'(periph_wait_gate), 0);
        check("R7 main stop clear", int'(main_osc_stop), 0);
        for (int c = 0; c < 4; c++) begin
            bus_write(1'b1, 8'(c << 6));
            settled_period(p);
            check($sformatf("R4 ratio code %0d", c), p, exp_p[c]);
        end
    endtask

    task automatic t_boundary;
        int n;
        int p;
        bus_write(1'b1, 8'hC0);
        settled_period(p);
        check("R11 setup period 16", p, 16);
        for (int i = 0; i < 64 && !cpu_clk_en; i++) @(negedge clk);
        n = 0;
        @(negedge clk); n++;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h40;
        @(negedge clk); n++;
        bus_wr = 1'b0;
        for (int i = 0; i < 64 && !cpu_clk_en; i++) begin
            @(negedge clk);
            n++;
        end
        check("R11 period in progress keeps old length", n, 16);
        measure_period(p);
        check("R11 next period uses new length", p, 2);
    endtask

    task automatic t_lso;
        osc_sel = 1'b1;
        bus_write(1'b1, 8'h10);
        read_chk("R6 write of 1 ignored", 1'b1, 8'h00);
        check("R6 lso output low", int'(lso_stop), 0);
        osc_sel = 1'b0;
        bus_write(1'b1, 8'h10);
        read_chk("R6 writable when main selected", 1'b1, 8'h10);
        check("R7 lso output follows bit", int'(lso_stop), 1);
        @(negedge clk);
        osc_sel = 1'b1;
        @(negedge clk);
        read_chk("R6 forced clear", 1'b1, 8'h00);
        osc_sel = 1'b0;
    endtask

    task automatic t_stop;
        int highs;
        int p;
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h00);
        bus_write(1'b1, 8'h01);
        read_chk("R5 reg1 drive set on stop", 1'b1, 8'h21);
        read_chk("R5 reg0 div8 set on stop", 1'b0, 8'h48);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cpu_clk_en) highs++;
        end
        check("R9 enable held low in stop", highs, 0);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        read_chk("R10 wake clears stop", 1'b1, 8'h20);
        settled_period(p);
        check("R5 divide-by-8 after stop", p, 8);
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h00);
        osc_sel = 1'b1;
        bus_write(1'b1, 8'h01);
        read_chk("R5 no side effect on oscillator clock reg1", 1'b1, 8'h01);
        read_chk("R5 no side effect on oscillator clock reg0", 1'b0, 8'h08);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        osc_sel = 1'b0;
        read_chk("R10 wake clears stop again", 1'b1, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_protect();
        t_reserved();
        t_ratios();
        t_boundary();
        t_lso();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule